// File: doc/BRIEF.md
# Vectored Interrupt Priority Tracker

This block keeps the pending, in-service and trigger-type state for a set of numbered interrupt vectors. It is 256 by default. Requests arrive on a single-vector port and are answered in the same cycle with an accept flag. The block ranks vectors in classes of sixteen. It combines a task-priority value with the class of the highest vector in service to form a processor priority. It offers the highest pending vector for delivery only when that vector's class is strictly above the processor priority.

A core takes an offered vector by pulsing an acknowledge. The vector then moves from pending to in service. An end-of-interrupt strobe retires the highest vector in service. When that vector arrived as a level request, the block raises a one-cycle broadcast that carries the vector number, so that the source can re-sample its line. Destination decoding, timers and the register bus are outside the block.

Top module: `vec_prio_tracker`

## Requirements
- R1: After reset the pending, in-service and trigger maps and the task priority are all clear: int_valid is 0, ppr_out is 0, tpr_rdata is 0 and no broadcast is raised.
- R2: A request is dropped unless both hw_en and sw_en are 1. A dropped request shows req_accepted 0 and changes no state.
- R3: req_accepted is 1 only when the vector's pending bit is clear. The bit is judged after any acknowledge in the same cycle has removed it. A repeated edge request (req_level 0) for a pending vector is reported as not accepted.
- R4: A level request (req_level 1) for a vector already pending is discarded and leaves the trigger map unchanged. An accepted request sets the vector's trigger bit when it is level and clears it when it is edge.
- R5: A task-priority write stores only bits [7:0] of tpr_wdata. The stored value is visible on tpr_rdata in the cycle after the write.
- R6: ppr_out equals the task priority when task bits [7:4] are greater than or equal to bits [7:4] of the highest in-service vector. Otherwise it equals that vector with bits [3:0] cleared. An empty in-service map counts as vector 0. ppr_out follows a change of map or task priority one cycle later.
- R7: int_valid is 1 only when the highest pending vector, with bits [3:0] cleared, is strictly greater than ppr_out. int_vec is then that vector.
- R8: int_ack is honoured only while int_valid is 1. It sets the in-service bit of int_vec and clears its pending bit.
- R9: eoi_strobe clears the highest in-service bit. With no bit in service it changes nothing.
- R10: When the retired vector's trigger bit was 1, that bit is cleared and eoi_bcast_valid is 1 for exactly the next cycle, with eoi_bcast_vec equal to the vector. An edge vector raises no broadcast.
- R11: An acknowledge and an end-of-interrupt in the same cycle both take effect. The retirement acts on the vectors that were in service before the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_en | input | 1 | Hardware enable |
| sw_en | input | 1 | Software enable |
| req_valid | input | 1 | Interrupt request strobe |
| req_vec | input | 8 | Requested vector |
| req_level | input | 1 | 1 = level request, 0 = edge request |
| req_accepted | output | 1 | Request newly accepted (same cycle) |
| int_valid | output | 1 | A vector is deliverable |
| int_vec | output | 8 | Deliverable vector |
| int_ack | input | 1 | Take the deliverable vector |
| tpr_we | input | 1 | Task-priority write strobe |
| tpr_wdata | input | 32 | Task-priority write data |
| tpr_rdata | output | 8 | Stored task priority |
| ppr_out | output | 8 | Processor priority |
| eoi_strobe | input | 1 | End-of-interrupt |
| eoi_bcast_valid | output | 1 | Level end-of-interrupt broadcast |
| eoi_bcast_vec | output | 8 | Broadcast vector |

## Verification
Two pairs of functions can land in the same cycle: an acknowledge together with an end-of-interrupt, and an acknowledge together with a new request for the very vector being taken. The bench provokes both by holding the strobes in one clock. For the first pair, it judges the outcome by the broadcast of the old in-service vector and by the processor priority of the newly taken one. For the second pair, the request must be accepted again. A later end-of-interrupt must then broadcast, which shows that the trigger bit written by the new request survived.

// File: rtl/vpt_pkg.sv
package vpt_pkg;
   localparam int unsigned VPT_NUM_VEC   = 256;
   localparam int unsigned VPT_CLASS_LOG = 4;
   localparam int unsigned VPT_TPR_IN_W  = 32;
endpackage

// File: rtl/vpt_find_top.sv
module vpt_find_top #(
   parameter int unsigned N         = 256,
   parameter int unsigned GROUP_LOG = 4,
   parameter bit          TWO_LEVEL = 1'b1
) (
   input  logic [N-1:0]         map,
   output logic                 found,
   output logic [$clog2(N)-1:0] idx
);
   localparam int unsigned IW   = $clog2(N);
   localparam int unsigned GSZ  = 1 << GROUP_LOG;
   localparam int unsigned NGRP = N / GSZ;
   localparam int unsigned GW   = (NGRP > 1) ? $clog2(NGRP) : 1;

   initial begin
      if ((1 << IW) != N) $error("N must be a power of two");
      if (GROUP_LOG >= IW) $error("GROUP_LOG too large");
   end

   assign found = |map;

   generate
      if (TWO_LEVEL) begin : g_tree
         logic [NGRP-1:0] grp_any;
         logic [GW-1:0]   grp_sel;
         logic [GSZ-1:0]  grp_bits;
         logic [GROUP_LOG-1:0] low_sel;
         for (genvar g = 0; g < NGRP; g++) begin : g_or
            assign grp_any[g] = |map[g*GSZ +: GSZ];
         end
         always_comb begin
            grp_sel = '0;
            for (int g = 0; g < NGRP; g++)
               if (grp_any[g]) grp_sel = GW'(g);
         end
         assign grp_bits = map[grp_sel*GSZ +: GSZ];
         always_comb begin
            low_sel = '0;
            for (int b = 0; b < GSZ; b++)
               if (grp_bits[b]) low_sel = GROUP_LOG'(b);
         end
         assign idx = {grp_sel[IW-GROUP_LOG-1:0], low_sel};
      end else begin : g_flat
         always_comb begin
            idx = '0;
            for (int i = 0; i < N; i++)
               if (map[i]) idx = IW'(i);
         end
      end
   endgenerate
endmodule

// File: rtl/vpt_prio_calc.sv
module vpt_prio_calc #(
   parameter int unsigned VW = 8,
   parameter int unsigned CB = 4
) (
   input  logic [VW-1:0] tpr,
   input  logic          isr_found,
   input  logic [VW-1:0] isr_top,
   output logic [VW-1:0] ppr
);
   logic [VW-1:0] isr_eff;

   initial if (CB >= VW) $error("class bits must be below vector width");

   assign isr_eff = isr_found ? isr_top : '0;

   always_comb begin
      if (tpr[VW-1:CB] >= isr_eff[VW-1:CB]) ppr = tpr;
      else                                  ppr = {isr_eff[VW-1:CB], {CB{1'b0}}};
   end
endmodule

// File: rtl/vec_prio_tracker.sv
module vec_prio_tracker
   import vpt_pkg::*;
#(
   parameter int unsigned NUM_VEC   = VPT_NUM_VEC,
   parameter int unsigned CLASS_LOG = VPT_CLASS_LOG,
   parameter int unsigned TPR_IN_W  = VPT_TPR_IN_W,
   parameter bit          TWO_LEVEL = 1'b1,
   localparam int unsigned VW       = $clog2(NUM_VEC)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                hw_en,
   input  logic                sw_en,
   input  logic                req_valid,
   input  logic [VW-1:0]       req_vec,
   input  logic                req_level,
   output logic                req_accepted,
   output logic                int_valid,
   output logic [VW-1:0]       int_vec,
   input  logic                int_ack,
   input  logic                tpr_we,
   input  logic [TPR_IN_W-1:0] tpr_wdata,
   output logic [VW-1:0]       tpr_rdata,
   output logic [VW-1:0]       ppr_out,
   input  logic                eoi_strobe,
   output logic                eoi_bcast_valid,
   output logic [VW-1:0]       eoi_bcast_vec
);
   initial begin
      if (TPR_IN_W < VW) $error("TPR_IN_W narrower than vector width");
      if (NUM_VEC < 4) $error("NUM_VEC too small");
   end

   logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
   logic [NUM_VEC-1:0] irr_n, isr_n, tmr_n, irr_mid;
   logic [VW-1:0]      tpr_q, ppr_q, ppr_n;
   logic               bc_v_q;
   logic [VW-1:0]      bc_vec_q;

   logic               irr_found, isr_found;
   logic [VW-1:0]      irr_top, isr_top;
   logic               ack_fire, eoi_fire, req_en;

   vpt_find_top #(.N(NUM_VEC), .GROUP_LOG(CLASS_LOG), .TWO_LEVEL(TWO_LEVEL)) u_irr_find (
      .map(irr_q), .found(irr_found), .idx(irr_top));

   vpt_find_top #(.N(NUM_VEC), .GROUP_LOG(CLASS_LOG), .TWO_LEVEL(TWO_LEVEL)) u_isr_find (
      .map(isr_q), .found(isr_found), .idx(isr_top));

   vpt_prio_calc #(.VW(VW), .CB(CLASS_LOG)) u_prio (
      .tpr(tpr_q), .isr_found(isr_found), .isr_top(isr_top), .ppr(ppr_n));

   // delivery decision
   assign int_valid = irr_found &&
                      ({irr_top[VW-1:CLASS_LOG], {CLASS_LOG{1'b0}}} > ppr_q);
   assign int_vec   = irr_top;
   assign ack_fire  = int_ack && int_valid;
   assign eoi_fire  = eoi_strobe && isr_found;
   assign req_en    = req_valid && hw_en && sw_en;

   always_comb begin
      irr_mid = irr_q;
      if (ack_fire) irr_mid[int_vec] = 1'b0;
      req_accepted = req_en && !irr_mid[req_vec];
      irr_n = irr_mid;
      if (req_accepted) irr_n[req_vec] = 1'b1;

      isr_n = isr_q;
      if (eoi_fire) isr_n[isr_top] = 1'b0;
      if (ack_fire) isr_n[int_vec] = 1'b1;

      tmr_n = tmr_q;
      if (eoi_fire) tmr_n[isr_top] = 1'b0;
      if (req_accepted) tmr_n[req_vec] = req_level;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irr_q    <= '0;
         isr_q    <= '0;
         tmr_q    <= '0;
         tpr_q    <= '0;
         ppr_q    <= '0;
         bc_v_q   <= 1'b0;
         bc_vec_q <= '0;
      end else begin
         irr_q  <= irr_n;
         isr_q  <= isr_n;
         tmr_q  <= tmr_n;
         ppr_q  <= ppr_n;
         if (tpr_we) tpr_q <= tpr_wdata[VW-1:0];
         bc_v_q <= eoi_fire && tmr_q[isr_top];
         if (eoi_fire) bc_vec_q <= isr_top;
      end
   end

   assign tpr_rdata       = tpr_q;
   assign ppr_out         = ppr_q;
   assign eoi_bcast_valid = bc_v_q;
   assign eoi_bcast_vec   = bc_vec_q;

   // R2
   dis_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !(hw_en && sw_en)) |-> !req_accepted);
   // R5
   tpr_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tpr_we |=> (tpr_rdata == $past(tpr_wdata[VW-1:0])));
   // R6
   ppr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (ppr_out >= $past(tpr_q)));
   // R7
   dlv_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int_valid |-> irr_q[int_vec]);
   // R8
   ack_sets_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int_ack && int_valid) |=> isr_q[$past(int_vec)]);
   // R10
   bcast_after_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_bcast_valid |-> $past(eoi_strobe));
endmodule

// File: tb/vec_prio_tracker_bench.sv
`timescale 1ns/1ps
module vec_prio_tracker_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hw_en = 1'b0, sw_en = 1'b0;
   logic        req_valid = 1'b0, req_level = 1'b0;
   logic [7:0]  req_vec = '0;
   logic        req_accepted;
   logic        int_valid;
   logic [7:0]  int_vec;
   logic        int_ack = 1'b0;
   logic        tpr_we = 1'b0;
   logic [31:0] tpr_wdata = '0;
   logic [7:0]  tpr_rdata, ppr_out;
   logic        eoi_strobe = 1'b0;
   logic        eoi_bcast_valid;
   logic [7:0]  eoi_bcast_vec;

   int n_run = 0, n_fail = 0;
   logic [7:0] bq[$];

   always #4 clk = ~clk;

   vec_prio_tracker u_vec_prio_tracker (
      .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .sw_en(sw_en),
      .req_valid(req_valid), .req_vec(req_vec), .req_level(req_level),
      .req_accepted(req_accepted), .int_valid(int_valid), .int_vec(int_vec),
      .int_ack(int_ack), .tpr_we(tpr_we), .tpr_wdata(tpr_wdata),
      .tpr_rdata(tpr_rdata), .ppr_out(ppr_out), .eoi_strobe(eoi_strobe),
      .eoi_bcast_valid(eoi_bcast_valid), .eoi_bcast_vec(eoi_bcast_vec));

   task automatic chk(string tag, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // broadcast monitor: pops expected vectors pushed by the driver
   always @(negedge clk) if (rst_n && eoi_bcast_valid) begin
      n_run++;
      if (bq.size() == 0) begin
         n_fail++;
         $display("FAIL R10 unexpected broadcast actual=0x%0h expected=none", eoi_bcast_vec);
      end else begin
         logic [7:0] e;
         e = bq.pop_front();
         if (eoi_bcast_vec != e) begin
            n_fail++;
            $display("FAIL R10 broadcast vector actual=0x%0h expected=0x%0h", eoi_bcast_vec, e);
         end
      end
   end

   task automatic settle(); @(negedge clk); endtask

   task automatic do_req(logic [7:0] v, logic lvl, logic exp, string tag);
      req_valid = 1'b1; req_vec = v; req_level = lvl;
      #1 chk(tag, int'(req_accepted), int'(exp));
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic do_tpr(logic [31:0] d);
      tpr_we = 1'b1; tpr_wdata = d;
      @(negedge clk);
      tpr_we = 1'b0;
   endtask

   task automatic do_ack();
      int_ack = 1'b1;
      @(negedge clk);
      int_ack = 1'b0;
   endtask

   task automatic do_eoi(bit bc, logic [7:0] v);
      if (bc) bq.push_back(v);
      eoi_strobe = 1'b1;
      @(negedge clk);
      eoi_strobe = 1'b0;
   endtask

   task automatic chk_dlv(logic v, logic [7:0] vec, string tag);
      chk({tag, " valid"}, int'(int_valid), int'(v));
      if (v) chk({tag, " vec"}, int'(int_vec), int'(vec));
   endtask

   initial begin
      #800000;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      settle();
      // R1 reset state
      chk("R1 int_valid", int'(int_valid), 0);
      chk("R1 ppr", int'(ppr_out), 0);
      chk("R1 tpr", int'(tpr_rdata), 0);
      chk("R1 bcast", int'(eoi_bcast_valid), 0);

      // R2 disabled unit drops requests
      hw_en = 1'b1; sw_en = 1'b0;
      do_req(8'h40, 1'b0, 1'b0, "R2 sw off");
      hw_en = 1'b0; sw_en = 1'b1;
      do_req(8'h40, 1'b0, 1'b0, "R2 hw off");
      settle();
      chk_dlv(1'b0, 8'h00, "R2 nothing pending");
      hw_en = 1'b1;

      // R3 first edge request accepted, repeat not
      do_req(8'h45, 1'b0, 1'b1, "R3 new edge");
      settle();
      chk_dlv(1'b1, 8'h45, "R7 offer 45");
      do_req(8'h45, 1'b0, 1'b0, "R3 dup edge");
      // R4 level request on pending edge vector discarded
      do_req(8'h45, 1'b1, 1'b0, "R4 dup level");

      // R5 / R6 / R7 task priority
      do_tpr(32'h1234_0050);
      chk("R5 tpr low byte", int'(tpr_rdata), 'h50);
      settle();
      chk("R6 ppr=tpr", int'(ppr_out), 'h50);
      chk_dlv(1'b0, 8'h00, "R7 blocked by tpr");
      do_tpr(32'h0000_003F);
      settle();
      chk_dlv(1'b1, 8'h45, "R7 class 4 above 3F");
      do_tpr(32'h0000_0040);
      settle();
      chk_dlv(1'b0, 8'h00, "R7 equal class blocked");
      do_tpr(32'h0);
      settle();

      // R8 acknowledge
      do_ack();
      settle();
      chk("R6 ppr from isr 45", int'(ppr_out), 'h40);
      chk_dlv(1'b0, 8'h00, "R8 pending cleared");
      do_req(8'h47, 1'b1, 1'b1, "R4 level 47 new");
      do_req(8'h90, 1'b1, 1'b1, "R4 level 90 new");
      do_req(8'h90, 1'b1, 1'b0, "R4 level 90 dup");
      settle();
      chk_dlv(1'b1, 8'h90, "R7 offer 90");
      do_ack();
      settle();
      chk("R6 ppr 90", int'(ppr_out), 'h90);
      chk_dlv(1'b0, 8'h00, "R7 47 under 90");

      // R9 / R10 end of interrupt
      do_eoi(1'b1, 8'h90);
      settle();
      chk("R9 ppr back to 40", int'(ppr_out), 'h40);
      chk_dlv(1'b0, 8'h00, "R7 47 equal class 40");
      do_eoi(1'b0, 8'h45);   // 45 was edge: no broadcast (R4 left trigger clear)
      settle();
      chk("R9 ppr 0", int'(ppr_out), 0);
      chk_dlv(1'b1, 8'h47, "R7 offer 47");
      do_eoi(1'b0, 8'h00);   // empty in-service map
      settle();
      chk("R9 empty eoi ppr", int'(ppr_out), 0);
      chk_dlv(1'b1, 8'h47, "R9 empty eoi keeps pending");

      // R6 tpr class vs isr class
      do_ack();
      do_tpr(32'h4A);
      settle();
      chk("R6 tpr class equal", int'(ppr_out), 'h4A);
      do_tpr(32'h35);
      settle();
      chk("R6 isr class higher", int'(ppr_out), 'h40);
      do_tpr(32'h0);

      // R11 ack and eoi same cycle
      do_req(8'h80, 1'b0, 1'b1, "R3 edge 80");
      settle();
      chk_dlv(1'b1, 8'h80, "R11 offer 80");
      bq.push_back(8'h47);
      int_ack = 1'b1; eoi_strobe = 1'b1;
      @(negedge clk);
      int_ack = 1'b0; eoi_strobe = 1'b0;
      settle();
      chk("R11 ppr 80", int'(ppr_out), 'h80);
      do_eoi(1'b0, 8'h80);
      settle();
      chk("R11 ppr 0", int'(ppr_out), 0);

      // R3 request for the vector being acknowledged
      do_req(8'hA0, 1'b0, 1'b1, "R3 edge A0");
      settle();
      chk_dlv(1'b1, 8'hA0, "R3 offer A0");
      req_valid = 1'b1; req_vec = 8'hA0; req_level = 1'b1; int_ack = 1'b1;
      #1 chk("R3 req during ack", int'(req_accepted), 1);
      @(negedge clk);
      req_valid = 1'b0; int_ack = 1'b0;
      settle();
      chk("R8 ppr A0", int'(ppr_out), 'hA0);
      chk_dlv(1'b0, 8'h00, "R7 A0 equal class");
      do_eoi(1'b1, 8'hA0);
      settle();
      chk_dlv(1'b1, 8'hA0, "R10 A0 still pending");
      do_ack();
      do_eoi(1'b0, 8'hA0);
      settle();
      chk("R10 queue drained", bq.size(), 0);
      chk("R9 final ppr", int'(ppr_out), 0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule